// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block owns the SDRAM control pins from the moment the controller leaves reset until the memory device can accept normal traffic. It walks a fixed sixteen-step program. Each step either places one command on the pins for a single clock, or holds a no-op while a wait counter runs down. The program holds the device in reset and then releases it. It raises the clock enable and writes the three mode registers. It then starts long ZQ calibration, closes all banks and issues one auto-refresh. Finally it raises a completion flag, which tells the surrounding controller that the normal scheduler may take the pins.

Every delay is a parameter counted in clocks. The only exception is the mode-register settle time, which is derived from the clock period. Each program step packs a completion flag, a timed flag, the reset and clock-enable levels, the command code, the bank and address, and a wait count. A wait counter gates the advance from one step to the next. All pin outputs are registered.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it is raised at any point in the program, the outputs are: `ddr_rst_n`=0, `ddr_cke`=0, command strobes {cs_n,ras_n,cas_n,we_n}=0111 (no-op), `ddr_ba`=0, `ddr_addr`=0 and `init_done`=0. After `rst` falls, the program restarts from its first step.
- R2: On the first clock edge with `rst` low, the outputs show `ddr_rst_n`=0, `ddr_cke`=0 and a no-op. These hold for exactly RST_HOLD_CK clocks.
- R3: Next, `ddr_rst_n`=1 with `ddr_cke`=0 and a no-op, for exactly CKE_WAIT_CK clocks.
- R4: Next, `ddr_cke`=1 with a no-op, for exactly RFC_CK+7 clocks. From here on, `ddr_rst_n` and `ddr_cke` stay high until reset.
- R5: The mode registers are written with code 0000 in the order MR2, MR1, MR0. Each write lasts one clock. MR2 uses bank 2, address 0x0000. MR1 uses bank 1, address 0x0004: DLL enabled (A0=0), additive latency 0 (A4:A3=00). MR0 uses bank 0, address 0x0210: burst length 8 fixed (A1:A0=00), sequential burst (A3=0), CAS latency 5 (A6:A4=001, A2=0), DLL reset off (A8=0). A no-op wait of MRD_CK clocks follows MR2 and also follows MR1.
- R6: After MR0, a no-op wait lasts max(12, ceil(15000/CK_PS)) clocks.
- R7: A ZQ calibration command (code 0110, bank 0, address 0x0400, A10 high) is issued for one clock. A no-op wait of ZQ_WAIT_CK clocks follows it.
- R8: A precharge-all (code 0010, bank 0, address 0x0400) is issued for one clock. A no-op wait of RP_CK clocks follows it.
- R9: An auto-refresh (code 0001, bank 0, address 0) is issued for one clock, followed by a no-op wait of RFC_CK clocks. Then `init_done` rises, together with a no-op and both `ddr_rst_n` and `ddr_cke` high, and it holds until reset.
- R10: No command other than no-op lasts more than one clock. `ddr_cke` is never high while `ddr_rst_n` is low, and the command is a no-op whenever `ddr_cke` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ddr_rst_n | output | 1 | Memory reset, active low |
| ddr_cke | output | 1 | Memory clock enable |
| ddr_cs_n | output | 1 | Chip select strobe |
| ddr_ras_n | output | 1 | Row strobe |
| ddr_cas_n | output | 1 | Column strobe |
| ddr_we_n | output | 1 | Write strobe |
| ddr_ba | output | 3 | Bank address |
| ddr_addr | output | 14 | Row/column address |
| init_done | output | 1 | Program complete; pins may be handed to the scheduler |

## Verification
The bench builds the sequencer with tiny delays: a 5-clock reset hold, a 7-clock clock-enable wait, a 6-clock refresh time, a 4-clock mode wait, a 9-clock calibration wait and a 3-clock precharge wait. With these values the whole program lasts a few dozen clocks, so every clock of it can be compared against a schedule computed from the step durations. It also sets a 1000 ps clock period, so that the 15 ns term outweighs the 12-clock floor; this exercises the maximum in the settle-time derivation. A reset is applied partway through the calibration wait, and then the program is replayed in full.

// File: rtl/ddr3_init_pkg.sv
package ddr3_init_pkg;
  localparam int IDX_W  = 4;
  localparam int BA_W   = 3;
  localparam int ADDR_W = 14;
  localparam int CNT_W  = 17;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_ZQC = 4'b0110,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef struct packed {
    logic              fin;
    logic              timed;
    logic              rst_n;
    logic              cke;
    cmd_e              cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  cnt;
  } step_t;

  // MR0: WR code A11:A9=001, DLL reset A8=0, CL5 A6:A4=001 A2=0, seq A3=0, BL8 A1:A0=00
  localparam logic [ADDR_W-1:0] MR0_VAL = ADDR_W'(14'b00_0010_0001_0000);
  // MR1: DLL on A0=0, AL A4:A3=00, drive A5/A1=0, Rtt A2=1
  localparam logic [ADDR_W-1:0] MR1_VAL = ADDR_W'(14'b00_0000_0000_0100);
  // MR2: CWL 5 (A5:A3=000), everything else default
  localparam logic [ADDR_W-1:0] MR2_VAL = '0;
  localparam logic [ADDR_W-1:0] A10_VAL = ADDR_W'(14'h0400);
endpackage

// File: rtl/ddr3_init_rom.sv
module ddr3_init_rom
  import ddr3_init_pkg::*;
#(
  parameter int RST_HOLD_CK = 40000,
  parameter int CKE_WAIT_CK = 100000,
  parameter int XPR_CK      = 147,
  parameter int MRD_CK      = 4,
  parameter int MOD_CK      = 12,
  parameter int ZQ_WAIT_CK  = 512,
  parameter int RP_CK       = 3,
  parameter int RFC_CK      = 140
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            ent
);
  function automatic step_t wait_step(logic rn, logic ck, int n);
    step_t s;
    s       = '0;
    s.timed = 1'b1;
    s.rst_n = rn;
    s.cke   = ck;
    s.cmd   = CMD_NOP;
    s.cnt   = CNT_W'(n);
    return s;
  endfunction

  function automatic step_t cmd_step(cmd_e c, logic [BA_W-1:0] b, logic [ADDR_W-1:0] a);
    step_t s;
    s       = '0;
    s.rst_n = 1'b1;
    s.cke   = 1'b1;
    s.cmd   = c;
    s.ba    = b;
    s.addr  = a;
    return s;
  endfunction

  always_comb begin
    unique case (idx)
      4'd0:    ent = wait_step(1'b0, 1'b0, RST_HOLD_CK);
      4'd1:    ent = wait_step(1'b1, 1'b0, CKE_WAIT_CK);
      4'd2:    ent = wait_step(1'b1, 1'b1, XPR_CK);
      4'd3:    ent = cmd_step(CMD_MRS, 3'd2, MR2_VAL);
      4'd4:    ent = wait_step(1'b1, 1'b1, MRD_CK);
      4'd5:    ent = cmd_step(CMD_MRS, 3'd1, MR1_VAL);
      4'd6:    ent = wait_step(1'b1, 1'b1, MRD_CK);
      4'd7:    ent = cmd_step(CMD_MRS, 3'd0, MR0_VAL);
      4'd8:    ent = wait_step(1'b1, 1'b1, MOD_CK);
      4'd9:    ent = cmd_step(CMD_ZQC, 3'd0, A10_VAL);
      4'd10:   ent = wait_step(1'b1, 1'b1, ZQ_WAIT_CK);
      4'd11:   ent = cmd_step(CMD_PRE, 3'd0, A10_VAL);
      4'd12:   ent = wait_step(1'b1, 1'b1, RP_CK);
      4'd13:   ent = cmd_step(CMD_REF, 3'd0, '0);
      4'd14:   ent = wait_step(1'b1, 1'b1, RFC_CK);
      default: begin
        ent     = cmd_step(CMD_NOP, 3'd0, '0);
        ent.fin = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ddr3_init_timer.sv
module ddr3_init_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  a_r2_countdown: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3_init_pkg::*;
#(
  parameter int RST_HOLD_CK = 40000,
  parameter int CKE_WAIT_CK = 100000,
  parameter int RFC_CK      = 140,
  parameter int MRD_CK      = 4,
  parameter int CK_PS       = 5000,
  parameter int ZQ_WAIT_CK  = 512,
  parameter int RP_CK       = 3
) (
  input  logic              clk,
  input  logic              rst,
  output logic              ddr_rst_n,
  output logic              ddr_cke,
  output logic              ddr_cs_n,
  output logic              ddr_ras_n,
  output logic              ddr_cas_n,
  output logic              ddr_we_n,
  output logic [BA_W-1:0]   ddr_ba,
  output logic [ADDR_W-1:0] ddr_addr,
  output logic              init_done
);
  localparam int XPR_CK    = RFC_CK + 7;
  localparam int MOD_NS_CK = (15000 + CK_PS - 1) / CK_PS;
  localparam int MOD_CK    = (MOD_NS_CK > 12) ? MOD_NS_CK : 12;

  logic [IDX_W-1:0]  idx;
  step_t             ent;
  logic              tmr_zero, step, tmr_load;
  logic              rst_n_q, cke_q, done_q;
  cmd_e              cmd_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;

  ddr3_init_rom #(
    .RST_HOLD_CK(RST_HOLD_CK), .CKE_WAIT_CK(CKE_WAIT_CK), .XPR_CK(XPR_CK),
    .MRD_CK(MRD_CK), .MOD_CK(MOD_CK), .ZQ_WAIT_CK(ZQ_WAIT_CK),
    .RP_CK(RP_CK), .RFC_CK(RFC_CK)
  ) rom_i (
    .idx (idx),
    .ent (ent)
  );

  assign step     = tmr_zero && !done_q;
  assign tmr_load = step && ent.timed;

  ddr3_init_timer #(.W(CNT_W)) tmr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (ent.cnt - CNT_W'(1)),
    .zero     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      rst_n_q <= 1'b0;
      cke_q   <= 1'b0;
      cmd_q   <= CMD_NOP;
      ba_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else if (step) begin
      idx     <= idx + IDX_W'(1);
      rst_n_q <= ent.rst_n;
      cke_q   <= ent.cke;
      cmd_q   <= ent.cmd;
      ba_q    <= ent.ba;
      addr_q  <= ent.addr;
      done_q  <= ent.fin;
    end
  end

  assign ddr_rst_n = rst_n_q;
  assign ddr_cke   = cke_q;
  assign {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n} = cmd_q;
  assign ddr_ba    = ba_q;
  assign ddr_addr  = addr_q;
  assign init_done = done_q;

  a_r10_cke_needs_rstn: assert property (@(posedge clk) disable iff (rst)
    cke_q |-> rst_n_q);
  a_r10_nop_while_cke_low: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> (cmd_q == CMD_NOP));
  a_r10_single_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP) |=> (cmd_q == CMD_NOP));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !tmr_zero |=> $stable({rst_n_q, cke_q, cmd_q, ba_q, addr_q, done_q}));
endmodule

// File: tb/ddr3_init_seq_tb_top.sv
module ddr3_init_seq_tb_top;
  localparam int P_HOLD = 5;
  localparam int P_CKEW = 7;
  localparam int P_RFC  = 6;
  localparam int P_MRD  = 4;
  localparam int P_CKPS = 1000;
  localparam int P_ZQ   = 9;
  localparam int P_RP   = 3;
  localparam int E_MOD  = ((15000 + P_CKPS - 1) / P_CKPS > 12) ? (15000 + P_CKPS - 1) / P_CKPS : 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ddr_rst_n, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n, init_done;
  logic [2:0]  ddr_ba;
  logic [13:0] ddr_addr;
  int n_chk = 0;
  int n_err = 0;
  int viol  = 0;
  logic [3:0] prev_cmd = 4'h7;
  bit   mon_on = 1'b0;

  always #10 clk = ~clk;

  ddr3_init_seq #(
    .RST_HOLD_CK(P_HOLD), .CKE_WAIT_CK(P_CKEW), .RFC_CK(P_RFC), .MRD_CK(P_MRD),
    .CK_PS(P_CKPS), .ZQ_WAIT_CK(P_ZQ), .RP_CK(P_RP)
  ) dut_i (
    .clk(clk), .rst(rst), .ddr_rst_n(ddr_rst_n), .ddr_cke(ddr_cke),
    .ddr_cs_n(ddr_cs_n), .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n),
    .ddr_we_n(ddr_we_n), .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
  );

  wire [3:0]  cmd_now = {ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n};
  wire [23:0] act = {init_done, ddr_rst_n, ddr_cke, cmd_now, ddr_ba, ddr_addr};
  localparam logic [23:0] RST_STATE = {3'b000, 4'h7, 3'd0, 14'h0};

  function automatic int dur(int k);
    case (k)
      0: return P_HOLD;
      1: return P_CKEW;
      2: return P_RFC + 7;
      4, 6: return P_MRD;
      8: return E_MOD;
      10: return P_ZQ;
      12: return P_RP;
      14: return P_RFC;
      default: return 1;
    endcase
  endfunction

  function automatic logic [23:0] expv(int k);
    case (k)
      0:  return {3'b000, 4'h7, 3'd0, 14'h0000};
      1:  return {3'b010, 4'h7, 3'd0, 14'h0000};
      3:  return {3'b011, 4'h0, 3'd2, 14'h0000};
      5:  return {3'b011, 4'h0, 3'd1, 14'h0004};
      7:  return {3'b011, 4'h0, 3'd0, 14'h0210};
      9:  return {3'b011, 4'h6, 3'd0, 14'h0400};
      11: return {3'b011, 4'h2, 3'd0, 14'h0400};
      13: return {3'b011, 4'h1, 3'd0, 14'h0000};
      15: return {3'b111, 4'h7, 3'd0, 14'h0000};
      default: return {3'b011, 4'h7, 3'd0, 14'h0000};
    endcase
  endfunction

  function automatic string tag(int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4, 5, 6, 7: return "R5";
      8: return "R6";
      9, 10: return "R7";
      11, 12: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string t, logic [23:0] a, logic [23:0] e);
    n_chk++;
    if (a !== e) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", t, a, e);
    end
  endtask

  // R10 monitor: no back-to-back commands, CKE only with reset released
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      if (cmd_now != 4'h7 && prev_cmd != 4'h7) viol++;
      if (ddr_cke && !ddr_rst_n) viol++;
      if (!ddr_cke && cmd_now != 4'h7) viol++;
      prev_cmd = cmd_now;
    end else begin
      prev_cmd = 4'h7;
    end
  end

  // Walk the program; stop_k >= 0 abandons it in that step's third clock
  task automatic run(int stop_k);
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < dur(k); j++) begin
        @(negedge clk);
        if (k == stop_k && j == 2) return;
        check(tag(k), act, expv(k));
      end
    end
    for (int h = 0; h < 20; h++) begin
      @(negedge clk);
      check("R9", act, expv(15));
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", act, RST_STATE);
    mon_on = 1'b1;
    run(-1);
    rst = 1'b1;
    @(negedge clk);
    check("R1", act, RST_STATE);
    run(10);
    rst = 1'b1;
    @(negedge clk);
    check("R1", act, RST_STATE);
    repeat (2) @(negedge clk);
    check("R1", act, RST_STATE);
    run(-1);
    check("R10", 24'(viol), 24'd0);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule